// File: doc/BRIEF.md
# Sliding-Cursor Last-Number Redial Comparator

This block keeps the last manually dialled number, up to 30 digits, and replays it to the dialer when the redial key is pressed. Behind a private branch exchange, the user often dials the exchange access digits by hand, waits for the second dial tone, and only then wants the rest of the stored number sent. To support this, each manually keyed digit is compared with the stored digit at the same position. If the digits keyed so far agree with the stored number, a redial press sends only the stored digits after the last keyed position.

When a keyed digit differs from the stored one, redial is locked out for the rest of the call and the newly keyed number takes the place of the old one. Digits keyed after a redial pass straight to the dialer and are never stored. With the compare mode disabled, every manual entry replaces the stored number, and redial works only before any digit has been keyed in the call.

Keys arrive on a valid/ready handshake and leave on a second valid/ready handshake toward the dialer. Keys are forwarded in the same cycle and are accepted only when the dialer is ready. Replayed digits come from the internal buffer. Going on-hook ends the call.

Top module: `lnr_slide_redial`

## Requirements
- R1: The buffer holds up to 30 digits. A replay emits the stored 4-bit digit codes unchanged, one per `out_valid && out_ready` transfer, in the order they were keyed.
- R2: While off-hook and not replaying, a key with `redial_req` low is offered to the dialer in the same cycle (`out_valid = key_valid`, `out_digit = key_digit`), and `key_ready` follows `out_ready`. While on-hook or replaying, `key_ready` is low.
- R3: When compare mode is off, or once the call is locked out, each accepted key is written at the current position and the stored length becomes that position plus one. This replaces the previous number.
- R4: The 31st digit keyed in one call raises `overflow` and empties the buffer, so redial emits nothing. Further digits in that call only pass to the dialer. The next call that keys 30 or fewer digits stores them again.
- R5: With `slide_en` high, no lockout, and every keyed digit so far equal to the stored digits, a redial press emits only the stored digits from the current cursor position to the end.
- R6: With `slide_en` high, the first keyed digit that differs from the stored one (or lies past the stored length) raises `lockout`. A locked-out redial emits nothing, and `lockout` stays high until on-hook.
- R7: Digits keyed after a redial has started are passed to the dialer and do not change the buffer.
- R8: A redial on a later call emits the stored number again when the earlier calls did not modify it.
- R9: Going on-hook (`hook_off` low) returns the cursor to 0 and clears `lockout`, `overflow` and an ongoing replay.
- R10: A redial press emits no digits if the buffer is empty or the cursor already equals the stored length.
- R11: During a replay with `out_ready` low, `out_valid` stays high and `out_digit` stays unchanged.
- R12: With `slide_en` low, a redial emits the whole stored number only if no digit has been keyed in the call. Otherwise it emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hook_off | input | 1 | High while the handset is off-hook |
| slide_en | input | 1 | Enables sliding-cursor compare mode |
| key_valid | input | 1 | A keyed digit is offered |
| key_ready | output | 1 | Keyed digit is accepted this cycle |
| key_digit | input | 4 | Keyed digit code |
| redial_req | input | 1 | One-cycle redial key strobe |
| out_valid | output | 1 | Digit offered to the dialer |
| out_ready | input | 1 | Dialer takes the digit |
| out_digit | output | 4 | Digit code to the dialer |
| lockout | output | 1 | Redial locked out by a mismatch |
| overflow | output | 1 | More than 30 digits keyed in this call |
| replaying | output | 1 | Stored digits are being emitted |

## Verification
The properties take for granted four things about the inputs: `redial_req` is a single-cycle strobe, `hook_off` is synchronous to `clk`, a keyed digit is held steady while it waits for `key_ready`, and the dialer may stall `out_ready` for any number of cycles. The stimulus tasks meet these conditions. They drive inputs on falling edges, hold `key_valid` until the key is taken, and pulse redial for exactly one cycle. They change the hook state only between calls, except for one deliberate drop in the middle of a stalled replay.

// File: rtl/lnr_pkg.sv
package lnr_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/lnr_store.sv
// Digit storage: one write port, two combinational read ports.
module lnr_store #(
  parameter int unsigned DEPTH = 30,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [PW-1:0]           wr_addr,
  input  lnr_pkg::digit_t         wr_data,
  input  logic [PW-1:0]           rda_addr,
  output lnr_pkg::digit_t         rda_data,
  input  logic [PW-1:0]           rdb_addr,
  output lnr_pkg::digit_t         rdb_data
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  lnr_pkg::digit_t mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_addr == PW'(i))) mem[i] <= wr_data;
    end
  end

  always_comb begin
    rda_data = '0;
    rdb_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rda_addr == PW'(i)) rda_data = mem[i];
      if (rdb_addr == PW'(i)) rdb_data = mem[i];
    end
    if (rda_addr > LAST) rda_data = '0;
    if (rdb_addr > LAST) rdb_data = '0;
  end
endmodule

// File: rtl/lnr_ctrl.sv
// Cursor, compare, lockout, overflow and replay sequencing.
module lnr_ctrl #(
  parameter int unsigned DEPTH = 30,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hook_off,
  input  logic            slide_en,
  input  logic            key_fire,
  input  lnr_pkg::digit_t key_digit,
  input  logic            redial_req,
  input  logic            out_fire,
  input  lnr_pkg::digit_t cmp_digit,
  output logic            wr_en,
  output logic [PW-1:0]   wr_addr,
  output logic [PW-1:0]   cmp_addr,
  output logic [PW-1:0]   emit_addr,
  output logic [PW-1:0]   len,
  output logic            locked,
  output logic            ovf,
  output logic            emitting
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] cnt_q, cnt_d, len_q, len_d, ptr_q, ptr_d;
  logic          lock_q, lock_d, ovf_q, ovf_d, post_q, post_d, emit_q, emit_d;

  always_comb begin
    cnt_d   = cnt_q;
    len_d   = len_q;
    ptr_d   = ptr_q;
    lock_d  = lock_q;
    ovf_d   = ovf_q;
    post_d  = post_q;
    emit_d  = emit_q;
    wr_en   = 1'b0;
    if (!hook_off) begin
      cnt_d  = '0;
      lock_d = 1'b0;
      ovf_d  = 1'b0;
      post_d = 1'b0;
      emit_d = 1'b0;
    end else if (emit_q) begin
      if (out_fire) begin
        if (ptr_q == len_q - ONE) emit_d = 1'b0;
        else                      ptr_d  = ptr_q + ONE;
      end
    end else if (redial_req) begin
      if (slide_en) begin
        if (!lock_q && (cnt_q < len_q)) begin
          emit_d = 1'b1;
          ptr_d  = cnt_q;
          post_d = 1'b1;
        end
      end else if ((cnt_q == '0) && (len_q != '0)) begin
        emit_d = 1'b1;
        ptr_d  = '0;
        post_d = 1'b1;
      end
    end else if (key_fire && !post_q) begin
      if (cnt_q == FULL) begin
        ovf_d = 1'b1;
        len_d = '0;
      end else if (slide_en && !lock_q && (cnt_q < len_q) && (key_digit == cmp_digit)) begin
        cnt_d = cnt_q + ONE;
      end else begin
        wr_en = 1'b1;
        len_d = cnt_q + ONE;
        cnt_d = cnt_q + ONE;
        if (slide_en) lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      ptr_q  <= '0;
      lock_q <= 1'b0;
      ovf_q  <= 1'b0;
      post_q <= 1'b0;
      emit_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      ptr_q  <= ptr_d;
      lock_q <= lock_d;
      ovf_q  <= ovf_d;
      post_q <= post_d;
      emit_q <= emit_d;
    end
  end

  assign wr_addr   = cnt_q;
  assign cmp_addr  = cnt_q;
  assign emit_addr = ptr_q;
  assign len       = len_q;
  assign locked    = lock_q;
  assign ovf       = ovf_q;
  assign emitting  = emit_q;
endmodule

// File: rtl/lnr_slide_redial.sv
module lnr_slide_redial #(
  parameter int unsigned DEPTH = 30
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hook_off,
  input  logic                        slide_en,
  input  logic                        key_valid,
  output logic                        key_ready,
  input  logic [lnr_pkg::DIGIT_W-1:0] key_digit,
  input  logic                        redial_req,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [lnr_pkg::DIGIT_W-1:0] out_digit,
  output logic                        lockout,
  output logic                        overflow,
  output logic                        replaying
);
  localparam int unsigned PW = $clog2(DEPTH + 1);

  logic            wr_en, key_fire, out_fire;
  logic [PW-1:0]   wr_addr, cmp_addr, emit_addr, stored_len;
  lnr_pkg::digit_t cmp_digit, emit_digit;

  assign key_ready = hook_off & ~replaying & ~redial_req & out_ready;
  assign key_fire  = key_valid & key_ready;
  assign out_valid = hook_off & (replaying | (key_valid & ~redial_req));
  assign out_digit = replaying ? emit_digit : key_digit;
  assign out_fire  = out_valid & out_ready;

  lnr_store #(.DEPTH(DEPTH), .PW(PW)) i_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (key_digit),
    .rda_addr (cmp_addr),
    .rda_data (cmp_digit),
    .rdb_addr (emit_addr),
    .rdb_data (emit_digit)
  );

  lnr_ctrl #(.DEPTH(DEPTH), .PW(PW)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hook_off   (hook_off),
    .slide_en   (slide_en),
    .key_fire   (key_fire),
    .key_digit  (key_digit),
    .redial_req (redial_req),
    .out_fire   (out_fire),
    .cmp_digit  (cmp_digit),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .cmp_addr   (cmp_addr),
    .emit_addr  (emit_addr),
    .len        (stored_len),
    .locked     (lockout),
    .ovf        (overflow),
    .emitting   (replaying)
  );
endmodule

// File: rtl/lnr_slide_redial_chk.sv
module lnr_slide_redial_chk #(
  parameter int unsigned DEPTH = 30,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        hook_off,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [lnr_pkg::DIGIT_W-1:0] out_digit,
  input logic                        key_ready,
  input logic                        lockout,
  input logic                        overflow,
  input logic                        replaying,
  input logic [PW-1:0]               len
);
  a_r1_len_max: assert property (@(posedge clk) disable iff (!rst_n)
    len <= PW'(DEPTH));

  a_r2_no_key_in_replay: assert property (@(posedge clk) disable iff (!rst_n)
    replaying |-> !key_ready);

  a_r4_overflow_no_replay: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !replaying);

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && hook_off) |=> lockout);

  a_r9_onhook_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !hook_off |=> (!lockout && !replaying && !overflow));

  a_r11_hold_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (replaying && hook_off && out_valid && !out_ready) |=>
      (!hook_off || (out_valid && $stable(out_digit))));
endmodule

bind lnr_slide_redial lnr_slide_redial_chk #(.DEPTH(DEPTH), .PW(PW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hook_off  (hook_off),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_digit (out_digit),
  .key_ready (key_ready),
  .lockout   (lockout),
  .overflow  (overflow),
  .replaying (replaying),
  .len       (stored_len)
);

// File: tb/test_lnr_slide_redial.sv
module test_lnr_slide_redial;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n, hook_off, slide_en, key_valid, redial_req, out_ready;
  logic [3:0] key_digit;
  logic key_ready, out_valid, lockout, overflow, replaying;
  logic [3:0] out_digit;

  int checks = 0, errors = 0, ncap = 0;
  logic [3:0] cap [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  lnr_slide_redial i_lnr_slide_redial (
    .clk(clk), .rst_n(rst_n), .hook_off(hook_off), .slide_en(slide_en),
    .key_valid(key_valid), .key_ready(key_ready), .key_digit(key_digit),
    .redial_req(redial_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_digit(out_digit), .lockout(lockout), .overflow(overflow),
    .replaying(replaying)
  );

  // capture transfers to the dialer just before each rising edge
  always @(negedge clk) begin
    #(CLK_PERIOD/2 - 1);
    if (rst_n && out_valid && out_ready && ncap < 64) begin
      cap[ncap] = out_digit;
      ncap++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_cap(input string tag, input logic [63:0] e, input int n);
    chk({tag, " digit count"}, ncap, n);
    for (int i = 0; i < n && i < ncap; i++)
      chk({tag, " digit"}, int'(cap[i]), int'(e[4*(n-1-i) +: 4]));
  endtask

  task automatic press_key(input logic [3:0] d);
    @(negedge clk);
    key_valid = 1'b1;
    key_digit = d;
    forever begin
      #(CLK_PERIOD/2 - 2);
      if (key_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic press_redial();
    @(negedge clk);
    redial_req = 1'b1;
    @(negedge clk);
    redial_req = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic new_call();
    @(negedge clk);
    hook_off = 1'b0;
    repeat (2) @(negedge clk);
    hook_off = 1'b1;
    @(negedge clk);
    ncap = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("reset out_valid", int'(out_valid), 0);
    chk("reset lockout", int'(lockout), 0);
    chk("reset overflow", int'(overflow), 0);
    chk("reset replaying", int'(replaying), 0);
    chk("R2 key_ready on-hook", int'(key_ready), 0);
  endtask

  task automatic t_empty();
    slide_en = 1'b0;
    new_call();
    press_redial();
    check_cap("R10 empty buffer", 64'h0, 0);
  endtask

  task automatic t_plain();
    slide_en = 1'b0;
    new_call();
    press_key(4'd1); press_key(4'd2); press_key(4'd3);
    check_cap("R2 passthrough", 64'h123, 3);
    new_call();
    press_redial();
    check_cap("R1 R3 plain replay", 64'h123, 3);
    press_key(4'd7);
    check_cap("R7 post digit out", 64'h1237, 4);
    new_call();
    press_redial();
    check_cap("R8 repeat after post digit", 64'h123, 3);
  endtask

  task automatic t_slide();
    slide_en = 1'b1;
    new_call();
    press_key(4'd1); press_key(4'd2);
    press_redial();
    check_cap("R5 remaining digits", 64'h123, 3);
    #1 chk("R5 no lockout on match", int'(lockout), 0);
    press_key(4'd9);
    new_call();
    press_redial();
    check_cap("R8 R7 repeat full", 64'h123, 3);
  endtask

  task automatic t_end();
    slide_en = 1'b1;
    new_call();
    press_key(4'd1); press_key(4'd2); press_key(4'd3);
    press_redial();
    check_cap("R10 cursor at end", 64'h123, 3);
  endtask

  task automatic t_mismatch();
    slide_en = 1'b1;
    new_call();
    press_key(4'd1); press_key(4'd5);
    #1 chk("R6 lockout raised", int'(lockout), 1);
    press_redial();
    check_cap("R6 locked redial silent", 64'h15, 2);
    press_key(4'd6);
    #1 chk("R6 lockout held", int'(lockout), 1);
    new_call();
    #1 chk("R9 lockout cleared", int'(lockout), 0);
    press_redial();
    check_cap("R3 R6 new number kept", 64'h156, 3);
  endtask

  task automatic t_en_off_keyed();
    slide_en = 1'b0;
    new_call();
    press_key(4'd1);
    press_redial();
    check_cap("R12 redial after key", 64'h1, 1);
  endtask

  task automatic t_backpressure();
    slide_en = 1'b0;
    new_call();
    press_key(4'd4); press_key(4'd7);
    new_call();
    out_ready = 1'b0;
    @(negedge clk); redial_req = 1'b1;
    @(negedge clk); redial_req = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 valid held", int'(out_valid), 1);
    chk("R11 digit held", int'(out_digit), 4);
    chk("R11 replaying", int'(replaying), 1);
    chk("R2 key_ready low in replay", int'(key_ready), 0);
    @(negedge clk); out_ready = 1'b1;
    repeat (10) @(negedge clk);
    check_cap("R11 R1 after stall", 64'h47, 2);
  endtask

  task automatic t_overflow();
    slide_en = 1'b0;
    new_call();
    for (int i = 0; i < 31; i++) press_key(4'(i % 10));
    chk("R4 all digits passed", ncap, 31);
    #1 chk("R4 overflow raised", int'(overflow), 1);
    ncap = 0;
    press_redial();
    chk("R4 no replay in call", ncap, 0);
    new_call();
    #1 chk("R9 overflow cleared", int'(overflow), 0);
    press_redial();
    check_cap("R4 buffer emptied", 64'h0, 0);
    new_call();
    press_key(4'd8); press_key(4'd2);
    new_call();
    press_redial();
    check_cap("R4 stores again", 64'h82, 2);
  endtask

  task automatic t_onhook_stop();
    new_call();
    out_ready = 1'b0;
    @(negedge clk); redial_req = 1'b1;
    @(negedge clk); redial_req = 1'b0;
    repeat (2) @(negedge clk);
    hook_off = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 replay stopped", int'(replaying), 0);
    chk("R9 no output on-hook", int'(out_valid), 0);
    out_ready = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hook_off = 1'b0; slide_en = 1'b0; key_valid = 1'b0;
    key_digit = '0; redial_req = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty();
    t_plain();
    t_slide();
    t_end();
    t_mismatch();
    t_en_off_keyed();
    t_backpressure();
    t_overflow();
    t_onhook_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule